// File: doc/BRIEF.md
# Multi-Level Address Translation Walker

This block turns a 64-bit logical address into a real address by walking translation tables held in memory. A root descriptor supplies the origin of the first table and a 2-bit type. The type picks where the walk starts: region-first, region-second, region-third or segment. The walker reads one 8-byte entry per level through a single-outstanding memory read port. It moves down through the region levels, then the segment level, then the page level, and returns the real address and whether the result may be written. If the walk cannot complete, it reports a fault with an exception type and a translation exception code (TEC).

The host drives `start_i` for one cycle while `busy_o` is low, together with the logical address, the root descriptor, the access kind, the address-space-control value and the enhanced-translation enable. Exactly one of `done_o` or `fault_o` is then raised for a single cycle. The result outputs are valid in that cycle and stay unchanged until the next start.

The controller moves through these states:

- `ST_IDLE` goes to `ST_CHECK` on start.
- `ST_CHECK` goes to `ST_DONE` for a real-space root, to `ST_FAULT` when the root-level checks fail, and otherwise to `ST_FETCH`.
- `ST_FETCH` raises a request, waits for the grant and then waits for read data. It goes to `ST_DECODE` when the data arrives.
- `ST_DECODE` goes to `ST_FETCH` for the next level, to `ST_DONE` at a leaf, or to `ST_FAULT`.
- `ST_DONE` and `ST_FAULT` return to `ST_IDLE` after one cycle.

Top module: `dat_walker`

## Requirements
- R1: When root bit 5 (real-space) is set, the walk ends in `done_o` with `raddr_o` equal to the page-aligned logical address, `wr_ok_o`=1 and no memory request.
- R2: Root type is held in root bits 3:2 (3 region-first, 2 region-second, 1 region-third, 0 segment). Nonzero logical bits 63:53 (type 2), 63:42 (type 1) or 63:31 (type 0) raise exception 0x38 with no memory read.
- R3: The top two index bits of the first level are bits 63:62, 52:51, 41:40 or 30:29 for types 3 to 0. If these bits exceed root bits 1:0, the walker raises that level's translation exception with no read. The codes are region-first 0x39, region-second 0x3A, region-third 0x3B and segment 0x10.
- R4: Each entry is read at origin + 8 × index. The indexes are logical bits 63:53, 52:42, 41:31 and 30:20 for the region-first to segment tables, and bits 19:12 for the page table. Region origins are entry bits 63:12, and the page table origin is segment entry bits 63:11. `mem_req_o` and `mem_addr_o` stay steady until `mem_gnt_i`, and only one read is outstanding at a time.
- R5: A region or segment entry with bit 5 (invalid) set raises the translation exception of the level it was read from. If the invalid bit is clear but the entry's type tag (bits 3:2) differs from the level, the walker raises translation-specification exception 0x12.
- R6: A region entry passes only when the next level's top two index bits lie between entry bits 7:6 (lowest allowed) and entry bits 1:0 (highest allowed). Otherwise the walker raises the next-lower level's translation exception.
- R7: Entry bit 9 (protect) clears write permission. For a region entry this happens only when `edat_i` is set; for a segment or page entry it always happens.
- R8: With `edat_i` set, a segment entry with bit 10 (frame) set ends the walk. The real address is then entry bits 63:20 joined with logical bits 19:12, with zeros below. With `edat_i` clear, bit 10 is ignored and the page level is read.
- R9: A page entry with bit 10 set raises page-translation exception 0x11. If bit 10 is clear and bit 8 is set, it raises 0x12. Otherwise `raddr_o` is entry bits 63:12 with zeros below.
- R10: A store access (`access_i`=1) whose finished walk has no write permission raises protection exception 0x04 instead of `done_o`.
- R11: On a fault, `tec_o` is the page-aligned logical address ORed with the following values: 0x400 for a store or 0x800 otherwise, 4 for a protection fault, and `asc_i` in bits 1:0. `ilen_o` is 2 when the access is an instruction fetch (`access_i`=2), and 0 otherwise.
- R12: After reset, the outputs `busy_o`, `done_o`, `fault_o` and `mem_req_o` are low. `done_o` and `fault_o` last one cycle, and `start_i` is ignored while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a walk (taken only when idle) |
| laddr_i | input | 64 | Logical address; bits 11:0 are ignored |
| root_i | input | 64 | Root descriptor: origin 63:12, real-space 5, type 3:2, length 1:0 |
| access_i | input | 2 | 0 read, 1 store, 2 instruction fetch |
| asc_i | input | 2 | Address-space-control value reported in the TEC |
| edat_i | input | 1 | Enhanced translation enable |
| mem_req_o | output | 1 | Table read request |
| mem_addr_o | output | 64 | Table entry address |
| mem_gnt_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read data valid (no earlier than the cycle after grant) |
| mem_rdata_i | input | 64 | Table entry |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Successful completion pulse |
| fault_o | output | 1 | Fault completion pulse |
| raddr_o | output | 64 | Real address |
| wr_ok_o | output | 1 | Result may be written |
| exc_o | output | 8 | Exception type |
| tec_o | output | 64 | Translation exception code |
| ilen_o | output | 2 | Instruction length reported with a fault |

## Verification
In one decode cycle, the segment-frame shortcut can end the walk at the same moment as the store-protection decision. The bench provokes this with a store to a frame segment entry that also carries the protect bit, and it expects a protection fault rather than completion. The same entry read without enhanced translation must instead fall through to a page-table read. A second pairing is the grant arriving in the very cycle the request rises, followed by data one cycle later. The bench runs this pairing against delayed grants and long read latencies, and checks every granted address against the reference model's expected address sequence.

// File: rtl/dat_walker_pkg.sv
package dat_walker_pkg;

    localparam int ADDR_W  = 64;
    localparam int IDX_W   = 11;
    localparam int PIDX_W  = 8;
    localparam int PAGE_SH = 12;

    localparam int ROOT_REAL = 5;
    localparam int ENT_INV   = 5;
    localparam int ENT_PROT  = 9;
    localparam int SEG_FRAME = 10;
    localparam int PTE_INV   = 10;
    localparam int PTE_RSV   = 8;

    localparam logic [1:0] ACC_READ  = 2'd0;
    localparam logic [1:0] ACC_STORE = 2'd1;
    localparam logic [1:0] ACC_FETCH = 2'd2;

    localparam logic [7:0] EXC_PROT = 8'h04;
    localparam logic [7:0] EXC_SEG  = 8'h10;
    localparam logic [7:0] EXC_PAGE = 8'h11;
    localparam logic [7:0] EXC_SPEC = 8'h12;
    localparam logic [7:0] EXC_ASCE = 8'h38;
    localparam logic [7:0] EXC_RG1  = 8'h39;
    localparam logic [7:0] EXC_RG2  = 8'h3A;
    localparam logic [7:0] EXC_RG3  = 8'h3B;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CHECK, ST_FETCH, ST_DECODE, ST_DONE, ST_FAULT
    } walk_state_e;

    function automatic logic [7:0] lvl_exc(input logic [1:0] lvl);
        unique case (lvl)
            2'd3:    return EXC_RG1;
            2'd2:    return EXC_RG2;
            2'd1:    return EXC_RG3;
            default: return EXC_SEG;
        endcase
    endfunction

    function automatic logic [1:0] top2_of(input logic [ADDR_W-1:0] a, input logic [1:0] lvl);
        unique case (lvl)
            2'd3:    return a[63:62];
            2'd2:    return a[52:51];
            2'd1:    return a[41:40];
            default: return a[30:29];
        endcase
    endfunction

endpackage

// File: rtl/dat_walk_index.sv
module dat_walk_index
    import dat_walker_pkg::*;
(
    input  logic [ADDR_W-1:0] laddr,
    input  logic [1:0]        lvl,
    input  logic              at_page,
    input  logic [ADDR_W-1:0] origin,
    output logic [ADDR_W-1:0] entry_addr
);
    localparam int PAD_W = ADDR_W - IDX_W - 3;

    logic [IDX_W-1:0] idx;

    always_comb begin
        if (at_page) begin
            idx = {{(IDX_W-PIDX_W){1'b0}}, laddr[PAGE_SH +: PIDX_W]};
        end else begin
            unique case (lvl)
                2'd3:    idx = laddr[63:53];
                2'd2:    idx = laddr[52:42];
                2'd1:    idx = laddr[41:31];
                default: idx = laddr[30:20];
            endcase
        end
    end

    assign entry_addr = origin + {{PAD_W{1'b0}}, idx, 3'b000};

endmodule

// File: rtl/dat_walk_decode.sv
module dat_walk_decode
    import dat_walker_pkg::*;
(
    input  logic [ADDR_W-1:0] entry,
    input  logic [ADDR_W-1:0] laddr,
    input  logic [1:0]        lvl,
    input  logic              at_page,
    input  logic              edat,
    output logic              fault,
    output logic [7:0]        exc,
    output logic              prot,
    output logic              leaf,
    output logic [ADDR_W-1:0] leaf_addr,
    output logic              to_page,
    output logic [ADDR_W-1:0] next_origin
);
    logic [1:0] nxt_top;
    assign nxt_top = top2_of(laddr, lvl - 2'd1);

    always_comb begin
        fault       = 1'b0;
        exc         = '0;
        prot        = 1'b0;
        leaf        = 1'b0;
        leaf_addr   = '0;
        to_page     = 1'b0;
        next_origin = '0;
        if (at_page) begin
            if (entry[PTE_INV]) begin
                fault = 1'b1;
                exc   = EXC_PAGE;
            end else if (entry[PTE_RSV]) begin
                fault = 1'b1;
                exc   = EXC_SPEC;
            end else begin
                leaf      = 1'b1;
                prot      = entry[ENT_PROT];
                leaf_addr = {entry[63:12], 12'h000};
            end
        end else if (entry[ENT_INV]) begin
            fault = 1'b1;
            exc   = lvl_exc(lvl);
        end else if (entry[3:2] != lvl) begin
            fault = 1'b1;
            exc   = EXC_SPEC;
        end else if (lvl == 2'd0) begin
            prot = entry[ENT_PROT];
            if (edat && entry[SEG_FRAME]) begin
                leaf      = 1'b1;
                leaf_addr = {entry[63:20], laddr[19:12], 12'h000};
            end else begin
                to_page     = 1'b1;
                next_origin = {entry[63:11], 11'h000};
            end
        end else if (nxt_top < entry[7:6] || nxt_top > entry[1:0]) begin
            fault = 1'b1;
            exc   = lvl_exc(lvl - 2'd1);
        end else begin
            prot        = edat & entry[ENT_PROT];
            next_origin = {entry[63:12], 12'h000};
        end
    end

endmodule

// File: rtl/dat_walker.sv
module dat_walker
    import dat_walker_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] laddr_i,
    input  logic [ADDR_W-1:0] root_i,
    input  logic [1:0]        access_i,
    input  logic [1:0]        asc_i,
    input  logic              edat_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_gnt_i,
    input  logic              mem_rvalid_i,
    input  logic [ADDR_W-1:0] mem_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              fault_o,
    output logic [ADDR_W-1:0] raddr_o,
    output logic              wr_ok_o,
    output logic [7:0]        exc_o,
    output logic [ADDR_W-1:0] tec_o,
    output logic [1:0]        ilen_o
);
    walk_state_e state_q, state_d;

    logic [ADDR_W-1:0] laddr_q, root_q, origin_q, entry_q, raddr_q;
    logic [1:0]        acc_q, asc_q, lvl_q;
    logic              edat_q, at_page_q, granted_q, wr_q, prot_flt_q;
    logic [7:0]        exc_q;

    logic [1:0] rtype;
    logic       too_wide, tl_over;
    assign rtype = root_q[3:2];

    // Root-level range checks, evaluated in ST_CHECK
    always_comb begin
        unique case (rtype)
            2'd3:    too_wide = 1'b0;
            2'd2:    too_wide = |laddr_q[63:53];
            2'd1:    too_wide = |laddr_q[63:42];
            default: too_wide = |laddr_q[63:31];
        endcase
        tl_over = top2_of(laddr_q, rtype) > root_q[1:0];
    end

    logic              d_fault, d_prot, d_leaf, d_to_page;
    logic [7:0]        d_exc;
    logic [ADDR_W-1:0] d_leaf_addr, d_next_origin;
    logic              wr_after, leaf_prot;

    dat_walk_index u_index (
        .laddr      (laddr_q),
        .lvl        (lvl_q),
        .at_page    (at_page_q),
        .origin     (origin_q),
        .entry_addr (mem_addr_o)
    );

    dat_walk_decode u_decode (
        .entry       (entry_q),
        .laddr       (laddr_q),
        .lvl         (lvl_q),
        .at_page     (at_page_q),
        .edat        (edat_q),
        .fault       (d_fault),
        .exc         (d_exc),
        .prot        (d_prot),
        .leaf        (d_leaf),
        .leaf_addr   (d_leaf_addr),
        .to_page     (d_to_page),
        .next_origin (d_next_origin)
    );

    assign wr_after  = wr_q & ~d_prot;
    assign leaf_prot = d_leaf && (acc_q == ACC_STORE) && !wr_after;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_CHECK;
            ST_CHECK: begin
                if (root_q[ROOT_REAL])         state_d = ST_DONE;
                else if (too_wide || tl_over)  state_d = ST_FAULT;
                else                           state_d = ST_FETCH;
            end
            ST_FETCH:  if (granted_q && mem_rvalid_i) state_d = ST_DECODE;
            ST_DECODE: begin
                if (d_fault || leaf_prot) state_d = ST_FAULT;
                else if (d_leaf)          state_d = ST_DONE;
                else                      state_d = ST_FETCH;
            end
            ST_DONE, ST_FAULT: state_d = ST_IDLE;
            default:           state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            laddr_q    <= '0;
            root_q     <= '0;
            origin_q   <= '0;
            entry_q    <= '0;
            raddr_q    <= '0;
            acc_q      <= ACC_READ;
            asc_q      <= '0;
            lvl_q      <= '0;
            edat_q     <= 1'b0;
            at_page_q  <= 1'b0;
            granted_q  <= 1'b0;
            wr_q       <= 1'b0;
            prot_flt_q <= 1'b0;
            exc_q      <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    laddr_q    <= {laddr_i[ADDR_W-1:PAGE_SH], {PAGE_SH{1'b0}}};
                    root_q     <= root_i;
                    acc_q      <= access_i;
                    asc_q      <= asc_i;
                    edat_q     <= edat_i;
                    wr_q       <= 1'b1;
                    prot_flt_q <= 1'b0;
                    exc_q      <= '0;
                    at_page_q  <= 1'b0;
                    granted_q  <= 1'b0;
                end
                ST_CHECK: begin
                    lvl_q    <= rtype;
                    origin_q <= {root_q[63:12], 12'h000};
                    raddr_q  <= laddr_q;
                    if (too_wide)     exc_q <= EXC_ASCE;
                    else if (tl_over) exc_q <= lvl_exc(rtype);
                end
                ST_FETCH: begin
                    if (!granted_q && mem_gnt_i)    granted_q <= 1'b1;
                    if (granted_q && mem_rvalid_i)  entry_q   <= mem_rdata_i;
                end
                ST_DECODE: begin
                    granted_q <= 1'b0;
                    wr_q      <= wr_after;
                    if (d_fault) begin
                        exc_q <= d_exc;
                    end else if (leaf_prot) begin
                        exc_q      <= EXC_PROT;
                        prot_flt_q <= 1'b1;
                    end else if (d_leaf) begin
                        raddr_q <= d_leaf_addr;
                    end else begin
                        origin_q <= d_next_origin;
                        if (d_to_page) at_page_q <= 1'b1;
                        else           lvl_q     <= lvl_q - 2'd1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        busy_o    = (state_q != ST_IDLE);
        done_o    = (state_q == ST_DONE);
        fault_o   = (state_q == ST_FAULT);
        mem_req_o = (state_q == ST_FETCH) && !granted_q;
        raddr_o   = raddr_q;
        wr_ok_o   = wr_q;
        exc_o     = exc_q;
        tec_o     = {laddr_q[63:12], (acc_q == ACC_STORE) ? 2'b01 : 2'b10,
                     7'b0, prot_flt_q, asc_q};
        ilen_o    = (fault_o && acc_q == ACC_FETCH) ? 2'd2 : 2'd0;
    end

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o)));

    assert_real_direct_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && root_q[ROOT_REAL]) |-> (raddr_o == laddr_q && wr_ok_o));

    assert_prot_store_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && exc_o == EXC_PROT) |-> (acc_q == ACC_STORE));

    assert_store_done_writable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && acc_q == ACC_STORE) |-> wr_ok_o);

    assert_result_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (raddr_o[11:0] == 12'h000));

    assert_rvalid_after_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH && mem_rvalid_i) |-> granted_q);

endmodule

// File: tb/dat_walker_tb.sv
module dat_walker_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] laddr_i = '0, root_i = '0;
    logic [1:0]  access_i = '0, asc_i = '0;
    logic        edat_i = 1'b0;
    logic        mem_req_o, mem_gnt_i = 1'b0, mem_rvalid_i = 1'b0;
    logic [63:0] mem_addr_o, mem_rdata_i = '0;
    logic        busy_o, done_o, fault_o, wr_ok_o;
    logic [63:0] raddr_o, tec_o;
    logic [7:0]  exc_o;
    logic [1:0]  ilen_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    dat_walker u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .laddr_i(laddr_i),
        .root_i(root_i), .access_i(access_i), .asc_i(asc_i), .edat_i(edat_i),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_gnt_i(mem_gnt_i),
        .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
        .busy_o(busy_o), .done_o(done_o), .fault_o(fault_o), .raddr_o(raddr_o),
        .wr_ok_o(wr_ok_o), .exc_o(exc_o), .tec_o(tec_o), .ilen_o(ilen_o)
    );

    int checks = 0;
    int errors = 0;
    string cur_tag = "R4";

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Table memory and reference walk
    logic [63:0] mem [logic [63:0]];
    logic [63:0] exp_q[$];

    function automatic logic [63:0] rd(logic [63:0] a);
        if (mem.exists(a)) return mem[a];
        return 64'h0;
    endfunction

    function automatic logic [7:0] exc_of(int l);
        case (l)
            3: return 8'h39;
            2: return 8'h3A;
            1: return 8'h3B;
            default: return 8'h10;
        endcase
    endfunction

    logic        e_fault, e_wr;
    logic [7:0]  e_exc;
    logic [63:0] e_raddr, e_tec;
    logic [1:0]  e_ilen;

    task automatic ref_walk(logic [63:0] la_in, logic [63:0] root, logic [1:0] acc,
                            logic [1:0] asc, logic ed);
        logic [63:0] la, org, e, a, pe;
        logic        stop, prot;
        int          rt, hi;
        la = la_in & ~64'hFFF;
        exp_q.delete();
        e_fault = 0; e_exc = 0; e_wr = 1; e_raddr = la; stop = 0; prot = 0;
        rt = int'(root[3:2]);
        if (root[5]) stop = 1;
        hi = (rt == 3) ? 64 : (rt == 2) ? 53 : (rt == 1) ? 42 : 31;
        if (!stop && hi < 64 && (la >> hi) != 0) begin e_fault = 1; e_exc = 8'h38; stop = 1; end
        if (!stop && ((la >> (29 + 11*rt)) & 3) > root[1:0]) begin
            e_fault = 1; e_exc = exc_of(rt); stop = 1;
        end
        org = root & ~64'hFFF;
        for (int l = rt; l >= 0 && !stop; l--) begin
            a = org + (((la >> (20 + 11*l)) & 64'h7FF) * 8);
            exp_q.push_back(a);
            e = rd(a);
            if (e[5]) begin e_fault = 1; e_exc = exc_of(l); stop = 1; end
            else if (int'(e[3:2]) != l) begin e_fault = 1; e_exc = 8'h12; stop = 1; end
            else if (l == 0) begin
                if (e[9]) e_wr = 0;
                stop = 1;
                if (ed && e[10]) e_raddr = (e & ~64'hFFFFF) | (la & 64'hFF000);
                else begin
                    a = (e & ~64'h7FF) + (((la >> 12) & 64'hFF) * 8);
                    exp_q.push_back(a);
                    pe = rd(a);
                    if (pe[10]) begin e_fault = 1; e_exc = 8'h11; end
                    else if (pe[8]) begin e_fault = 1; e_exc = 8'h12; end
                    else begin
                        if (pe[9]) e_wr = 0;
                        e_raddr = pe & ~64'hFFF;
                    end
                end
            end else begin
                if (((la >> (29 + 11*(l-1))) & 3) < e[7:6] ||
                    ((la >> (29 + 11*(l-1))) & 3) > e[1:0]) begin
                    e_fault = 1; e_exc = exc_of(l-1); stop = 1;
                end else begin
                    if (ed && e[9]) e_wr = 0;
                    org = e & ~64'hFFF;
                end
            end
        end
        if (!e_fault && acc == 2'd1 && !e_wr) begin e_fault = 1; e_exc = 8'h04; prot = 1; end
        e_tec  = la | ((acc == 2'd1) ? 64'h400 : 64'h800) | (prot ? 64'h4 : 64'h0) | {62'h0, asc};
        e_ilen = (e_fault && acc == 2'd2) ? 2'd2 : 2'd0;
    endtask

    // Memory responder, compares every granted address with the model
    int gnt_delay = 0, rd_lat = 0, wait_cnt = 0, rd_cnt = 0;
    logic        rd_pend = 0;
    logic [63:0] pend_addr = '0;

    always @(negedge clk) begin
        mem_rvalid_i = 1'b0;
        mem_gnt_i    = 1'b0;
        if (rd_pend) begin
            if (rd_cnt == 0) begin
                mem_rvalid_i = 1'b1;
                mem_rdata_i  = rd(pend_addr);
                rd_pend      = 1'b0;
            end else rd_cnt--;
        end
        if (mem_req_o && !rd_pend) begin
            if (wait_cnt >= gnt_delay) begin
                mem_gnt_i = 1'b1;
                wait_cnt  = 0;
                rd_pend   = 1'b1;
                rd_cnt    = rd_lat;
                pend_addr = mem_addr_o;
                if (exp_q.size() == 0) chk(cur_tag, "unexpected read", mem_addr_o, 64'hX);
                else chk(cur_tag, "read address", mem_addr_o, exp_q.pop_front());
            end else wait_cnt++;
        end
    end

    int total_cyc = 0;
    always @(posedge clk) begin
        total_cyc++;
        if (total_cyc > 150000) begin
            errors++;
            $display("FAIL R12 global watchdog: actual %0d expected <150000", total_cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic run(string tag, logic [63:0] la, logic [63:0] root, logic [1:0] acc,
                       logic [1:0] asc, logic ed, int gd, int lt, logic poke);
        int cyc;
        cur_tag = tag;
        ref_walk(la, root, acc, asc, ed);
        gnt_delay = gd; rd_lat = lt;
        @(negedge clk);
        laddr_i = la; root_i = root; access_i = acc; asc_i = asc; edat_i = ed;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            @(negedge clk);
            start_i = 1'b1; root_i = 64'h20; laddr_i = 64'hDEAD_0000;
            @(negedge clk);
            start_i = 1'b0;
        end
        cyc = 0;
        while (!(done_o || fault_o) && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        if (cyc >= 2000) begin
            errors++;
            $display("FAIL %s watchdog: actual timeout expected completion", tag);
        end else begin
            chk(tag, "fault flag", {63'h0, fault_o}, {63'h0, e_fault});
            if (e_fault) begin
                chk(tag, "exception", {56'h0, exc_o}, {56'h0, e_exc});
                chk(tag, "tec", tec_o, e_tec);
                chk(tag, "ilen", {62'h0, ilen_o}, {62'h0, e_ilen});
            end else begin
                chk(tag, "raddr", raddr_o, e_raddr);
                chk(tag, "wr_ok", {63'h0, wr_ok_o}, {63'h0, e_wr});
            end
            chk(tag, "reads left", 64'(exp_q.size()), 64'h0);
            @(negedge clk);
            chk("R12", "pulse width", {62'h0, done_o, fault_o}, 64'h0);
        end
        exp_q.delete();
    endtask

    localparam logic [63:0] R1ROOT  = 64'h10000 | (64'd3 << 2) | 64'd3;
    localparam logic [63:0] R3ROOT  = 64'h30000 | (64'd1 << 2) | 64'd3;
    localparam logic [63:0] SEGROOT = 64'h40000 | 64'd3;

    initial begin
        // Tables
        mem[64'h10000 + 8]  = 64'h20000 | (64'd3 << 2) | 64'd3;
        mem[64'h20000 + 16] = 64'h30000 | (64'd2 << 2) | 64'd3;
        mem[64'h30000 + 24] = 64'h40000 | (64'd1 << 2) | 64'd3;
        mem[64'h30000 + 40] = 64'h40000 | (64'd1 << 6) | (64'd1 << 2) | 64'd1;
        mem[64'h30000 + 64] = 64'h40000 | 64'h200 | (64'd1 << 2) | 64'd3;
        mem[64'h40000 + 32] = 64'h50800;
        mem[64'h40000 + 48] = 64'h20;
        mem[64'h40000 + 56] = 64'h4;
        mem[64'h40000 + 72] = 64'h12300000 | 64'h400;
        mem[64'h40000 + 80] = 64'h50800 | 64'h200;
        mem[64'h40000 + 88] = 64'h60000;
        mem[64'h40000 + 96] = 64'h12300000 | 64'h400 | 64'h200;
        mem[64'h50800 + 40] = 64'h777000;
        mem[64'h60000 + 48] = 64'h400;
        mem[64'h60000 + 56] = 64'h100;

        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12", "reset outputs", {60'h0, busy_o, done_o, fault_o, mem_req_o}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12", "idle after reset", {63'h0, busy_o}, 64'h0);

        run("R4", (64'd1<<53)|(64'd2<<42)|(64'd3<<31)|(64'd4<<20)|(64'd5<<12),
            R1ROOT, 2'd0, 2'd0, 1'b0, 0, 0, 1'b0);
        run("R4", (64'd1<<53)|(64'd2<<42)|(64'd3<<31)|(64'd4<<20)|(64'd5<<12)|64'h123,
            R1ROOT, 2'd1, 2'd1, 1'b1, 2, 3, 1'b0);
        run("R1", 64'hABCD_E123, 64'h20 | SEGROOT, 2'd1, 2'd0, 1'b0, 0, 0, 1'b0);
        run("R2", 64'd1 << 40, SEGROOT, 2'd0, 2'd0, 1'b0, 0, 0, 1'b0);
        run("R2", 64'd1 << 50, R3ROOT, 2'd1, 2'd2, 1'b0, 0, 0, 1'b0);
        run("R3", 64'd1 << 40, 64'h30000 | (64'd1 << 2), 2'd0, 2'd0, 1'b0, 0, 0, 1'b0);
        run("R5", 64'd6 << 20, SEGROOT, 2'd0, 2'd0, 1'b0, 0, 1, 1'b0);
        run("R5", 64'd7 << 20, SEGROOT, 2'd0, 2'd0, 1'b0, 0, 0, 1'b0);
        run("R6", 64'd5 << 31, R3ROOT, 2'd0, 2'd0, 1'b0, 0, 0, 1'b0);
        run("R6", (64'd5 << 31) | (64'd1 << 29), R3ROOT, 2'd0, 2'd0, 1'b0, 1, 0, 1'b0);
        run("R7", (64'd8<<31)|(64'd4<<20)|(64'd5<<12), R3ROOT, 2'd1, 2'd0, 1'b0, 0, 0, 1'b0);
        run("R10", (64'd8<<31)|(64'd4<<20)|(64'd5<<12), R3ROOT, 2'd1, 2'd3, 1'b1, 0, 0, 1'b0);
        run("R7", (64'd10<<20)|(64'd5<<12), SEGROOT, 2'd0, 2'd0, 1'b0, 0, 0, 1'b0);
        run("R10", (64'd10<<20)|(64'd5<<12), SEGROOT, 2'd1, 2'd1, 1'b0, 0, 2, 1'b0);
        run("R8", (64'd9<<20)|(64'h45<<12), SEGROOT, 2'd1, 2'd0, 1'b1, 0, 0, 1'b0);
        run("R8", (64'd9<<20)|(64'h45<<12), SEGROOT, 2'd0, 2'd0, 1'b0, 0, 0, 1'b0);
        run("R10", (64'd12<<20)|(64'h45<<12), SEGROOT, 2'd1, 2'd2, 1'b1, 0, 0, 1'b0);
        run("R8", (64'd12<<20)|(64'h45<<12), SEGROOT, 2'd0, 2'd2, 1'b1, 0, 0, 1'b0);
        run("R9", (64'd11<<20)|(64'd6<<12), SEGROOT, 2'd0, 2'd0, 1'b0, 0, 0, 1'b0);
        run("R9", (64'd11<<20)|(64'd7<<12), SEGROOT, 2'd1, 2'd1, 1'b0, 0, 0, 1'b0);
        run("R11", 64'd6 << 20, SEGROOT, 2'd2, 2'd3, 1'b0, 0, 0, 1'b0);
        run("R12", (64'd1<<53)|(64'd2<<42)|(64'd3<<31)|(64'd4<<20)|(64'd5<<12),
            R1ROOT, 2'd0, 2'd0, 1'b0, 1, 5, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule